// File: doc/BRIEF.md
# Microprogram Sequencer with Subroutine and Loop Stack

This block chooses the address of the next microinstruction for a microcoded control unit. The microword now executing sits in a pipeline register. The sequencer decodes that word and computes the next address combinationally. An external microcode store answers the address with the next word within the same cycle. At the clock edge that word enters the pipeline register, and its address enters the micro-PC. The fetch of one word therefore overlaps the execution of the word before it.

The next address comes from one of several sources. The default is the micro-PC plus one. The others are:
- the branch field of the microword;
- a dispatch address, formed from the opcode bits of the instruction register plus a base;
- a fixed vector address.

A six-entry LIFO holds return addresses and loop start addresses. A loop register counts iterations. Conditional branches test ALU flags that a status register captured one cycle earlier. An interrupt request overrides every other source and cancels the stack, loop and count actions of the current word.

Microword layout, with AW as the address width:
- branch/count field: bits [AW-1:0]
- select field: [AW+1:AW]
- condition enable: AW+2
- flag index: [AW+4:AW+3]
- condition invert: AW+5
- push: AW+6
- pop: AW+7
- loop: AW+8
- count load: AW+9
- datapath control field: CW bits from AW+10 upward

Top module: `useq_top`

## Requirements
- R1: While `rst` is high, `uaddr` shows 0 and `stk_err` is 0. The first cycle after release executes the word at address 0, so `cur_addr` is 0.
- R2: With select field 00 and no stack or loop bit set, the next address is `cur_addr`+1.
- R3: With select field 01, the next address is the branch field, bits [AW-1:0].
- R4: With select field 10, the next address is MAP_BASE plus `opcode`.
- R5: With the condition enable bit (AW+2) set, the branch is taken only when the status bit is true. The status bit is the one chosen by flag index [AW+4:AW+3] among `alu_flags` captured at the previous edge, inverted when bit AW+5 is set. A test that fails gives a plain increment.
- R6: `ctrl_out` carries the control field of the word at `cur_addr`, which was fetched when that address was on `uaddr` one cycle earlier.
- R7: A word with push (bit AW+6) stores `cur_addr`+1 on the stack. A later word with pop (bit AW+7) jumps to the stored value.
- R8: A count-load word (bit AW+9) sets the counter to branch[CNTW-1:0]. A loop word (bit AW+8) returns to the stack top and decrements the counter while it is nonzero. Once the counter is zero, the loop word pops the stack and increments. With count n, the loop body runs n+1 times.
- R9: A push onto a full stack (DEPTH entries) sets `stk_err` and leaves the stack unchanged, so the next pop still returns the last value stored.
- R10: A pop from an empty stack sets `stk_err`, and the next address is `cur_addr`+1.
- R11: With `irq` high, `uaddr` is VEC_ADDR. Select field 11 also gives VEC_ADDR.
- R12: `stk_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, forces the vector address |
| opcode | input | OPW | Opcode bits of the instruction register, used for dispatch |
| alu_flags | input | 4 | Live ALU flags, captured into the status register every cycle |
| mword | input | MW | Microword read from the store at `uaddr` |
| uaddr | output | AW | Next microinstruction address, to the microcode store |
| cur_addr | output | AW | Address of the word in the pipeline register |
| ctrl_out | output | CW | Datapath control field of the executing word |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions assume well-formed microwords. No word sets push together with pop or loop. A word sets count load and loop together only with the understanding that the load wins. `irq` holds a value for a whole cycle. Under these assumptions, the stack pointer and the counter move by at most one per cycle. The bench's microcode store keeps to this: every word has at most one stack bit. `irq` is raised for exactly one cycle while a plain increment word executes. `alu_flags` change only at mid-cycle points, one of which is the deliberate flip that shows a branch follows the registered flags and not the live ones.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEL_INC = 2'b00,
    SEL_BR  = 2'b01,
    SEL_MAP = 2'b10,
    SEL_VEC = 2'b11
  } nsel_e;
endpackage

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 6,
  parameter int DEPTH = 6,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          peek,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          full,
  output logic          err
);
  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic           err_q;
  logic           do_push, do_pop;

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == SPW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign top     = empty ? '0 : mem[sp_q - SPW'(1)];
  assign err     = err_q;

  // storage without reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (do_push) mem[sp_q] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (do_push)      sp_q <= sp_q + SPW'(1);
      else if (do_pop)  sp_q <= sp_q - SPW'(1);
      if ((push && full) || ((pop || peek) && empty)) err_q <= 1'b1;
    end
  end

  // R9
  ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (sp_q == $past(sp_q)) && err_q);
  // R10
  udf_err_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> err_q);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));
endmodule

// File: rtl/useq_loopcnt.sv
module useq_loopcnt #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            dec,
  output logic            zero
);
  logic [CNTW-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (dec && !zero)   cnt_q <= cnt_q - CNTW'(1);
  end

  // R8
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !zero) |=> cnt_q == $past(cnt_q) - CNTW'(1));
  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int OPW      = 3,
  parameter int MAP_BASE = 8,
  parameter int VEC_ADDR = 60
) (
  input  nsel_e          sel,
  input  logic [AW-1:0]  br,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  upc,
  input  logic [AW-1:0]  top,
  input  logic           empty,
  input  logic           cnt_zero,
  input  logic           irq,
  input  logic           take,
  input  logic           f_push,
  input  logic           f_pop,
  input  logic           f_loop,
  input  logic           f_ldcnt,
  output logic [AW-1:0]  y,
  output logic           push_o,
  output logic           pop_o,
  output logic           peek_o,
  output logic           dec_o,
  output logic           ld_o
);
  logic          active;
  logic [AW-1:0] inc;

  assign active = !irq && take;
  assign inc    = upc + AW'(1);

  // pop wins over loop, both win over push
  assign pop_o  = active && (f_pop || (f_loop && cnt_zero));
  assign peek_o = active && !f_pop && f_loop && !cnt_zero;
  assign dec_o  = peek_o && !empty;
  assign push_o = active && f_push && !f_pop && !f_loop;
  assign ld_o   = active && f_ldcnt;

  always_comb begin
    if (irq)                  y = AW'(VEC_ADDR);
    else if (!take)           y = inc;
    else if (f_pop)           y = empty ? inc : top;
    else if (f_loop)          y = (empty || cnt_zero) ? inc : top;
    else begin
      unique case (sel)
        SEL_INC: y = inc;
        SEL_BR:  y = br;
        SEL_MAP: y = AW'(MAP_BASE) + AW'(opcode);
        SEL_VEC: y = AW'(VEC_ADDR);
        default: y = inc;
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CW       = 4,
  parameter int OPW      = 3,
  parameter int CNTW     = 4,
  parameter int DEPTH    = 6,
  parameter int MAP_BASE = 8,
  parameter int VEC_ADDR = 60,
  localparam int MW      = AW + 10 + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq,
  input  logic [OPW-1:0] opcode,
  input  logic [3:0]     alu_flags,
  input  logic [MW-1:0]  mword,
  output logic [AW-1:0]  uaddr,
  output logic [AW-1:0]  cur_addr,
  output logic [CW-1:0]  ctrl_out,
  output logic           stk_err
);
  localparam int B_SEL  = AW;
  localparam int B_CEN  = AW + 2;
  localparam int B_CSEL = AW + 3;
  localparam int B_CINV = AW + 5;
  localparam int B_PUSH = AW + 6;
  localparam int B_POP  = AW + 7;
  localparam int B_LOOP = AW + 8;
  localparam int B_LD   = AW + 9;
  localparam int B_CTRL = AW + 10;
  // reset leaves an unconditional jump to address 0 in the pipeline
  localparam logic [MW-1:0] RST_WORD = MW'(SEL_BR) << B_SEL;

  logic [MW-1:0] pipe_q;
  logic [AW-1:0] upc_q;
  logic [3:0]    stat_q;

  logic [AW-1:0] f_br;
  nsel_e         f_sel;
  logic          f_cen, f_cinv, f_push, f_pop, f_loop, f_ld;
  logic [1:0]    f_csel;
  logic          take;

  assign f_br   = pipe_q[AW-1:0];
  assign f_sel  = nsel_e'(pipe_q[B_SEL +: 2]);
  assign f_cen  = pipe_q[B_CEN];
  assign f_csel = pipe_q[B_CSEL +: 2];
  assign f_cinv = pipe_q[B_CINV];
  assign f_push = pipe_q[B_PUSH];
  assign f_pop  = pipe_q[B_POP];
  assign f_loop = pipe_q[B_LOOP];
  assign f_ld   = pipe_q[B_LD];
  assign take   = !f_cen || (stat_q[f_csel] ^ f_cinv);

  logic [AW-1:0] top;
  logic          empty, full, cnt_zero;
  logic          push_r, pop_r, peek_r, dec_r, ld_r;
  logic [AW-1:0] y;

  useq_nextaddr #(
    .AW(AW), .OPW(OPW), .MAP_BASE(MAP_BASE), .VEC_ADDR(VEC_ADDR)
  ) u_next (
    .sel(f_sel), .br(f_br), .opcode(opcode), .upc(upc_q), .top(top),
    .empty(empty), .cnt_zero(cnt_zero), .irq(irq), .take(take),
    .f_push(f_push), .f_pop(f_pop), .f_loop(f_loop), .f_ldcnt(f_ld),
    .y(y), .push_o(push_r), .pop_o(pop_r), .peek_o(peek_r),
    .dec_o(dec_r), .ld_o(ld_r)
  );

  useq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push_r), .pop(pop_r), .peek(peek_r),
    .push_val(upc_q + AW'(1)), .top(top), .empty(empty), .full(full),
    .err(stk_err)
  );

  useq_loopcnt #(.CNTW(CNTW)) u_cnt (
    .clk(clk), .rst(rst), .load(ld_r), .load_val(f_br[CNTW-1:0]),
    .dec(dec_r), .zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= RST_WORD;
      upc_q  <= '0;
      stat_q <= '0;
    end else begin
      pipe_q <= mword;
      upc_q  <= y;
      stat_q <= alu_flags;
    end
  end

  assign uaddr    = y;
  assign cur_addr = upc_q;
  assign ctrl_out = pipe_q[B_CTRL +: CW];

  // R6
  pipe_load_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pipe_q == $past(mword));
  // R2
  upc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> upc_q == $past(uaddr));
  // R5
  status_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q == $past(alu_flags));
  // R11
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> uaddr == AW'(VEC_ADDR));
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  localparam int AW = 6, CW = 4, OPW = 3, MW = AW + 10 + CW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           irq = 1'b0;
  logic [OPW-1:0] opcode = '0;
  logic [3:0]     alu_flags = '0;
  logic [MW-1:0]  mword;
  logic [AW-1:0]  uaddr, cur_addr;
  logic [CW-1:0]  ctrl_out;
  logic           stk_err;

  logic [1:0] csel_v = '0;
  logic       cinv_v = 1'b0;
  logic [3:0] cnt_v  = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  useq_top uut (
    .clk(clk), .rst(rst), .irq(irq), .opcode(opcode), .alu_flags(alu_flags),
    .mword(mword), .uaddr(uaddr), .cur_addr(cur_addr), .ctrl_out(ctrl_out),
    .stk_err(stk_err)
  );

  function automatic logic [MW-1:0] mk(input logic [5:0] a, input logic [1:0] sel,
      input logic cen, input logic [1:0] cs, input logic ci, input logic pu,
      input logic po, input logic lp, input logic ld, input logic [5:0] br);
    return {a[3:0], ld, lp, po, pu, ci, cs, cen, sel, br};
  endfunction

  function automatic logic [MW-1:0] rom(input logic [5:0] a, input logic [1:0] cs,
      input logic ci, input logic [3:0] n);
    logic [MW-1:0] w;
    w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd0);
    case (a)
      6'd0:  w = mk(a, 2'b10, 0, 0, 0, 0, 0, 0, 0, 6'd0);
      6'd9:  w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd16);
      6'd10: w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd24);
      6'd11: w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd28);
      6'd12: w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd44);
      6'd13: w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd54);
      6'd14: w = mk(a, 2'b01, 0, 0, 0, 0, 0, 0, 0, 6'd56);
      6'd15: w = mk(a, 2'b11, 0, 0, 0, 0, 0, 0, 0, 6'd0);
      6'd16: w = mk(a, 2'b01, 1, cs, ci, 0, 0, 0, 0, 6'd20);
      6'd24: w = mk(a, 2'b01, 0, 0, 0, 1, 0, 0, 0, 6'd40);
      6'd40: w = mk(a, 2'b00, 0, 0, 0, 0, 1, 0, 0, 6'd0);
      6'd28: w = mk(a, 2'b00, 0, 0, 0, 0, 0, 0, 1, {2'b00, n});
      6'd29: w = mk(a, 2'b00, 0, 0, 0, 1, 0, 0, 0, 6'd0);
      6'd30: w = mk(a, 2'b00, 0, 0, 0, 0, 0, 0, 0, 6'd0);
      6'd31: w = mk(a, 2'b00, 0, 0, 0, 0, 0, 1, 0, 6'd0);
      6'd44, 6'd45, 6'd46, 6'd47, 6'd48, 6'd49, 6'd50:
             w = mk(a, 2'b00, 0, 0, 0, 1, 0, 0, 0, 6'd0);
      6'd51: w = mk(a, 2'b00, 0, 0, 0, 0, 1, 0, 0, 6'd0);
      6'd54: w = mk(a, 2'b00, 0, 0, 0, 0, 1, 0, 0, 6'd0);
      6'd56: w = mk(a, 2'b00, 0, 0, 0, 0, 0, 0, 0, 6'd0);
      default: ;
    endcase
    return w;
  endfunction

  assign mword = rom(uaddr, csel_v, cinv_v, cnt_v);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic expect_a(input int e, input string tag);
    tick();
    chk(cur_addr == AW'(e), tag, cur_addr, e);
    chk(ctrl_out == CW'(e), "R6 ctrl field follows executing word", ctrl_out, e & 15);
  endtask

  task automatic start(input int op);
    rst = 1'b1;
    irq = 1'b0;
    opcode = OPW'(op);
    tick();
    tick();
    chk(uaddr == '0, "R1 uaddr in reset", uaddr, 0);
    chk(stk_err == 1'b0, "R1 err cleared by reset", stk_err, 0);
    rst = 1'b0;
    expect_a(0, "R1 first word at 0");
    expect_a(8 + op, "R4 dispatch by opcode");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R4 dispatch sweep over every opcode; R11 vector through select 11
    for (int op = 0; op < 8; op++) begin
      start(op);
      if (op == 0) expect_a(0, "R3 branch to 0");
      if (op == 7) begin
        expect_a(60, "R11 select field vector");
        expect_a(0, "R3 branch after vector");
      end
    end

    // R5 conditional branch: all flags, both polarities, both values
    for (int cs = 0; cs < 4; cs++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int fv = 0; fv < 2; fv++) begin
          logic [3:0] fl;
          csel_v = 2'(cs);
          cinv_v = 1'(ci);
          fl = (fv != 0) ? (4'b1 << cs) : ~(4'b1 << cs);
          alu_flags = fl;
          start(1);
          expect_a(16, "R3 branch to test word");
          alu_flags = ~fl;  // live flags disagree with the registered ones
          expect_a(((fv ^ ci) != 0) ? 20 : 17, "R5 conditional uses latched flag");
          expect_a(0, "R3 return to fetch");
        end
      end
    end
    alu_flags = '0;

    // R7 call and return
    start(2);
    expect_a(24, "R3 jump to call");
    expect_a(40, "R7 call target");
    expect_a(25, "R7 return to call+1");
    expect_a(0, "R7 after return");
    chk(stk_err == 1'b0, "R7 no stack error", stk_err, 0);

    // R8 loop counts 0..15
    for (int n = 0; n < 16; n++) begin
      cnt_v = 4'(n);
      start(3);
      expect_a(28, "R3 jump to loop setup");
      expect_a(29, "R2 increment");
      expect_a(30, "R2 increment to loop start");
      expect_a(31, "R8 first body pass");
      for (int i = 0; i < n; i++) begin
        expect_a(30, "R8 loop back");
        expect_a(31, "R8 loop end word");
      end
      expect_a(32, "R8 loop exit");
      expect_a(0, "R8 after exit");
      chk(stk_err == 1'b0, "R8 no stack error", stk_err, 0);
    end

    // R9 overflow, R12 sticky
    start(4);
    for (int a = 44; a <= 50; a++) expect_a(a, "R2 push chain");
    chk(stk_err == 1'b0, "R9 no error before overflow", stk_err, 0);
    expect_a(51, "R9 next after failed push");
    chk(stk_err == 1'b1, "R9 overflow flagged", stk_err, 1);
    expect_a(50, "R9 stack top unchanged");
    tick();
    tick();
    chk(stk_err == 1'b1, "R12 error sticky", stk_err, 1);

    // R10 underflow
    start(5);
    expect_a(54, "R3 jump to pop");
    expect_a(55, "R10 empty pop increments");
    chk(stk_err == 1'b1, "R10 underflow flagged", stk_err, 1);
    expect_a(0, "R10 continues");

    // R11 interrupt request
    start(6);
    expect_a(56, "R3 jump to plain word");
    irq = 1'b1;
    #1;
    chk(uaddr == AW'(60), "R11 irq drives vector", uaddr, 60);
    expect_a(60, "R11 irq vector taken");
    irq = 1'b0;
    expect_a(0, "R11 after vector");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule